// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a small bidirectional register that, on every rising clock edge, performs exactly one of four operations chosen by a two-bit mode input. It can keep its contents, move every bit one place toward the most significant end, move every bit one place toward the least significant end, or take a whole new word from its parallel inputs. Each shift direction has its own serial input, which fills the position left empty by the shift.

The register width is a parameter with a default of four bits. Output bit 0 is the least significant position. An active-low clear input zeroes the whole word on the next clock edge and takes priority over the mode. The block is intended as a building piece for serial-to-parallel and parallel-to-serial conversion, simple state registers and bit-serial datapaths within one clock domain.

Top module: `usr_shift4`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `q` becomes all zeros after that edge, whatever the values of `mode`, the serial inputs and `par_in`.
- R2: When `clr_n` is 1 and `mode` is 2'b00 (hold) at an edge, `q` keeps its value.
- R3: When `clr_n` is 1 and `mode` is 2'b01 (shift toward the MSB) at an edge, `q[0]` takes `ser_right_in` and each `q[i]` for i of 1 or more takes the old `q[i-1]`.
- R4: When `clr_n` is 1 and `mode` is 2'b10 (shift toward the LSB) at an edge, `q[WIDTH-1]` takes `ser_left_in` and each `q[i]` below it takes the old `q[i+1]`.
- R5: When `clr_n` is 1 and `mode` is 2'b11 (load) at an edge, `q` takes `par_in`, with `par_in[i]` going to `q[i]`.
- R6: Bits move by exactly one position per edge: a bit given on `ser_right_in` in mode 2'b01 reaches `q[WIDTH-1]` after WIDTH edges, and a bit given on `ser_left_in` in mode 2'b10 reaches `q[0]` after WIDTH edges.
- R7: The serial input of the direction not selected, and `par_in` outside load mode, have no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, overrides mode |
| mode | input | 2 | Operation: 00 hold, 01 shift toward MSB, 10 shift toward LSB, 11 load |
| ser_right_in | input | 1 | Serial input entering `q[0]` in mode 01 |
| ser_left_in | input | 1 | Serial input entering `q[WIDTH-1]` in mode 10 |
| par_in | input | WIDTH | Parallel load word |
| q | output | WIDTH | Register contents, bit 0 least significant |

## Verification
The contents are the output, so a wrong next-state choice in any bit position shows on `q` right after the edge where it happens, with no hidden delay. A swapped neighbour connection or a wrong serial input shows as a misplaced bit after one shift, and as a wrong bit at the far end of the word after WIDTH shifts. A clear that loses to the mode shows as a nonzero word right after a clear edge in load mode.

// File: rtl/usr_pkg.sv
// Package: shared mode encoding for the universal shift register.
// Assumes the two-bit mode field is decoded exactly as listed here.
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_LOAD  = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_cell.sv
// Module: usr_cell
// Next-state selector for one bit position. Picks between its own bit,
// the lower neighbour, the upper neighbour and the parallel bit.
// Assumes the caller supplies the serial inputs at the word ends.
module usr_cell
    import usr_pkg::*;
(
    input  usr_mode_e mode,
    input  logic      cur_bit,
    input  logic      from_lower,
    input  logic      from_upper,
    input  logic      load_bit,
    output logic      next_bit
);

    // Four-way select of the next value for this position.
    always_comb begin
        case (mode)
            MODE_HOLD:  next_bit = cur_bit;
            MODE_RIGHT: next_bit = from_lower;
            MODE_LEFT:  next_bit = from_upper;
            MODE_LOAD:  next_bit = load_bit;
            default:    next_bit = cur_bit;
        endcase
    end

endmodule

// File: rtl/usr_reg.sv
// Module: usr_reg
// Flop bank holding the register word with a synchronous active-low clear.
// Assumes the clear has priority over the supplied next value.
module usr_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Capture the next word, or zero it when clear is low.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/usr_shift4.sv
// Module: usr_shift4
// Universal shift register: hold, shift toward MSB, shift toward LSB or
// parallel load, one operation per rising edge. Bit 0 is the LSB.
// Assumes a single clock domain and WIDTH of at least 2.
module usr_shift4
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_right_in,
    input  logic             ser_left_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);

    localparam int MSB = WIDTH - 1;

    usr_mode_e        mode_e;
    logic [WIDTH-1:0] lower_src;
    logic [WIDTH-1:0] upper_src;
    logic [WIDTH-1:0] next_q;

    // Convert the raw mode field to the shared enum.
    always_comb begin
        mode_e = usr_mode_e'(mode);
    end

    // Neighbour wiring, with serial inputs entering at the two ends.
    always_comb begin
        lower_src = {q[MSB-1:0], ser_right_in};
        upper_src = {ser_left_in, q[MSB:1]};
    end

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_cell
            usr_cell u_cell (
                .mode       (mode_e),
                .cur_bit    (q[gi]),
                .from_lower (lower_src[gi]),
                .from_upper (upper_src[gi]),
                .load_bit   (par_in[gi]),
                .next_bit   (next_q[gi])
            );
        end
    endgenerate

    usr_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (next_q),
        .q     (q)
    );

endmodule

// File: rtl/usr_shift4_chk.sv
// Module: usr_shift4_chk
// Checker for usr_shift4, bound to every instance. Relates the word after
// each edge to the inputs and the word before it.
module usr_shift4_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       mode,
    input logic             ser_right_in,
    input logic             ser_left_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q
);

    assert_clear_R1: assert property (@(posedge clk)
        !clr_n |=> (q == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && mode == 2'b00) |=> $stable(q));

    assert_shift_up_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && mode == 2'b01) |=>
            (q == {$past(q[WIDTH-2:0]), $past(ser_right_in)}));

    assert_shift_down_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && mode == 2'b10) |=>
            (q == {$past(ser_left_in), $past(q[WIDTH-1:1])}));

    assert_load_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && mode == 2'b11) |=> (q == $past(par_in)));

endmodule

bind usr_shift4 usr_shift4_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .clr_n        (clr_n),
    .mode         (mode),
    .ser_right_in (ser_right_in),
    .ser_left_in  (ser_left_in),
    .par_in       (par_in),
    .q            (q)
);

// File: tb/tb_usr_shift4.sv
// Bench for usr_shift4: vector table, directed serial tests, random mix
// against a model built from the requirements.
module tb_usr_shift4;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int NVEC = 13;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         ser_right_in = 1'b0;
    logic         ser_left_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    usr_shift4 #(.WIDTH(W)) dut (
        .clk          (clk),
        .clr_n        (clr_n),
        .mode         (mode),
        .ser_right_in (ser_right_in),
        .ser_left_in  (ser_left_in),
        .par_in       (par_in),
        .q            (q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Fields: {clr_n, mode, ser_right_in, ser_left_in, par_in, expected q}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1, 2'b11, 1'b0, 1'b0, 4'b1010, 4'b1010},  // R5 load
        {1'b1, 2'b00, 1'b0, 1'b0, 4'b0101, 4'b1010},  // R2 hold, R7 par ignored
        {1'b1, 2'b01, 1'b1, 1'b0, 4'b0000, 4'b0101},  // R3
        {1'b1, 2'b01, 1'b0, 1'b1, 4'b1111, 4'b1010},  // R3, R7 left in ignored
        {1'b1, 2'b10, 1'b0, 1'b1, 4'b0000, 4'b1101},  // R4, R7 right in ignored
        {1'b1, 2'b10, 1'b1, 1'b0, 4'b1111, 4'b0110},  // R4
        {1'b0, 2'b11, 1'b1, 1'b1, 4'b1111, 4'b0000},  // R1 clear beats load
        {1'b1, 2'b11, 1'b0, 1'b0, 4'b1001, 4'b1001},  // R5
        {1'b1, 2'b10, 1'b1, 1'b0, 4'b0110, 4'b0100},  // R4
        {1'b1, 2'b01, 1'b1, 1'b0, 4'b0110, 4'b1001},  // R3
        {1'b1, 2'b00, 1'b1, 1'b1, 4'b0000, 4'b1001},  // R2, R7
        {1'b1, 2'b11, 1'b0, 1'b0, 4'b1111, 4'b1111},  // R5
        {1'b0, 2'b00, 1'b0, 1'b0, 4'b0000, 4'b0000}   // R1
    };

    task automatic check(input string req, input logic [W-1:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected=%b at %0t", req, q, exp, $time);
        end
    endtask

    // Apply inputs, take one edge, then sample shortly after it.
    task automatic step(input logic c, input logic [1:0] m, input logic sr,
                        input logic sl, input logic [W-1:0] p);
        @(negedge clk);
        clr_n = c; mode = m; ser_right_in = sr; ser_left_in = sl; par_in = p;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [W-1:0] model;

        // Reset state (R1)
        step(1'b0, 2'b11, 1'b1, 1'b1, 4'b1111);
        check("R1", 4'b0000);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][12], VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
            check($sformatf("R1-R7 vec %0d", i), VEC[i][3:0]);
        end

        // R6: a single one travels toward the MSB, one place per edge
        step(1'b0, 2'b00, 1'b0, 1'b0, '0);
        step(1'b1, 2'b01, 1'b1, 1'b0, '0);
        check("R6", 4'b0001);
        for (int k = 1; k < W; k++) begin
            step(1'b1, 2'b01, 1'b0, 1'b1, '0);
            check("R6", 4'b0001 << k);
        end

        // R6: a single one travels toward the LSB
        step(1'b0, 2'b00, 1'b0, 1'b0, '0);
        step(1'b1, 2'b10, 1'b0, 1'b1, '0);
        check("R6", 4'b1000);
        for (int k = 1; k < W; k++) begin
            step(1'b1, 2'b10, 1'b1, 1'b0, '0);
            check("R6", 4'b1000 >> k);
        end

        // Random mix against a model of R1-R5
        model = q;
        for (int n = 0; n < 300; n++) begin
            logic c, sr, sl;
            logic [1:0] m;
            logic [W-1:0] p;
            c  = ($urandom_range(15) != 0);
            m  = 2'($urandom_range(3));
            sr = 1'($urandom_range(1));
            sl = 1'($urandom_range(1));
            p  = W'($urandom_range(15));
            if (!c)              model = '0;
            else if (m == 2'b01) model = {model[W-2:0], sr};
            else if (m == 2'b10) model = {sl, model[W-1:1]};
            else if (m == 2'b11) model = p;
            step(c, m, sr, sl, p);
            check("R1-R5 random", model);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule